// File: doc/BRIEF.md
# Eight-entry floating-point register stack

This block holds the operand registers of a floating-point unit as a circular file of eight entries, addressed relative to a top-of-stack pointer. Each entry has a tag bit that says whether it holds a live value. Commands can push a value, read a stack-relative slot (and optionally pop afterwards), exchange the top slot with another slot (and optionally pop afterwards), rotate the pointer up or down, and reinitialise the stack. Data words are opaque and parameterised in width.

Faults are found by inspecting tags, not by keeping a depth count. A push into a live entry is an overflow. A reference to an empty entry is an underflow. A faulting command leaves the stack exactly as it was. It raises a stack-fault pulse and an invalid-operation pulse for an external status unit, together with a direction bit. The pointer can be rotated modulo 8 without any change to tags or data, so software can treat the file as flat registers.

Top module: `fpstk_file`

## Requirements
- R1: After reset, and one cycle after an init command (`cmd_op` = 6), `top_o` is 0 and `tags_o` is all zero (bit n set means physical entry n is valid).
- R2: A push (`cmd_op` = 1) onto an empty target first moves `top_o` to (top-1) mod 8, then stores `wr_data` there and sets that tag. A read (`cmd_op` = 2) of slot ST(i), where i = `cmd_idx`, returns physical entry (top+i) mod 8 on `rd_data`, with `rd_valid` high for one cycle.
- R3: A push whose target entry (top-1) mod 8 is already valid is an overflow. `stk_fault`, `inv_op` and `c1_dir` are all high for one cycle, and `top_o`, `tags_o` and the stored data are left unchanged.
- R4: A read or exchange is an underflow when it references an empty entry. The referenced entries are ST(i), plus ST(0) for an exchange or whenever `cmd_pop` is set. On underflow, `stk_fault` and `inv_op` are high, `c1_dir` is low and `rd_valid` is low, and there is no change to the pointer, tags or data.
- R5: With `cmd_pop` set, a successful read or exchange first completes as the non-pop form, then clears the ST(0) tag and moves `top_o` to (top+1) mod 8. Without `cmd_pop`, `top_o` is unchanged.
- R6: Increment (`cmd_op` = 4) and decrement (`cmd_op` = 5) change `top_o` by +1 and -1 modulo 8, wrapping at both ends. They leave tags and data untouched.
- R7: An exchange (`cmd_op` = 3) with both ST(0) and ST(i) valid swaps their contents in a single cycle.
- R8: The fault outputs are one-cycle pulses. They are low after any command without a fault, and `c1_dir` is low whenever `stk_fault` is low.
- R9: Results appear in the cycle after the clock edge that accepts a command. With `cmd_valid` low, or with `cmd_op` equal to 0 or 7, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R1-R9 encodings) |
| cmd_idx | input | 3 | Stack-relative slot index i |
| cmd_pop | input | 1 | Pop after a read or exchange |
| wr_data | input | W | Value to push |
| rd_data | output | W | Value of the last successful read |
| rd_valid | output | 1 | One-cycle pulse for a successful read |
| top_o | output | 3 | Physical index of ST(0) |
| tags_o | output | 8 | Valid tag per physical entry |
| stk_fault | output | 1 | Stack fault pulse |
| inv_op | output | 1 | Invalid-operation pulse |
| c1_dir | output | 1 | Fault direction, 1 overflow, 0 underflow |

## Verification
The hardest case to reach is a fault after the pointer has been rotated away from the tags. For example, a push lands on a live entry only because of earlier increments, or an underflow occurs on ST(i) while ST(0) is valid. Directed sequences fill all eight entries, rotate the pointer through both wrap points and then push, pop and exchange. A long seeded random mix weighted towards pushes and rotations then keeps the stack near full and near empty, where such cases arise naturally. A bench-side model predicts every output.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_PUSH = 3'd1,
    OP_READ = 3'd2,
    OP_XCHG = 3'd3,
    OP_INCP = 3'd4,
    OP_DECP = 3'd5,
    OP_INIT = 3'd6,
    OP_RSVD = 3'd7
  } stk_op_e;
endpackage

// File: rtl/fpstk_ctrl.sv
// Command decode and fault detection; purely combinational.
module fpstk_ctrl #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [PW-1:0]    cmd_idx,
  input  logic             cmd_pop,
  input  logic [PW-1:0]    top_q,
  input  logic [DEPTH-1:0] tags_q,
  output logic [PW-1:0]    top_nxt,
  output logic [PW-1:0]    addr_dec,
  output logic [PW-1:0]    addr_rel,
  output logic             ovf,
  output logic             unf,
  output logic             do_push,
  output logic             do_read,
  output logic             do_xchg,
  output logic             do_pop,
  output logic             do_init
);
  import fpstk_pkg::*;

  stk_op_e op;
  logic    ref_bad;
  logic    need_top;

  always_comb begin
    op       = stk_op_e'(cmd_op);
    addr_dec = top_q - PW'(1);
    addr_rel = top_q + cmd_idx;
    need_top = (op == OP_XCHG) || cmd_pop;
    ref_bad  = !tags_q[addr_rel] || (need_top && !tags_q[top_q]);

    ovf     = cmd_valid && (op == OP_PUSH) && tags_q[addr_dec];
    unf     = cmd_valid && ((op == OP_READ) || (op == OP_XCHG)) && ref_bad;
    do_push = cmd_valid && (op == OP_PUSH) && !ovf;
    do_read = cmd_valid && (op == OP_READ) && !unf;
    do_xchg = cmd_valid && (op == OP_XCHG) && !unf;
    do_pop  = (do_read || do_xchg) && cmd_pop;
    do_init = cmd_valid && (op == OP_INIT);

    top_nxt = top_q;
    if (do_init)                                top_nxt = '0;
    else if (do_push)                           top_nxt = addr_dec;
    else if (do_pop)                            top_nxt = top_q + PW'(1);
    else if (cmd_valid && (op == OP_INCP))      top_nxt = top_q + PW'(1);
    else if (cmd_valid && (op == OP_DECP))      top_nxt = top_q - PW'(1);
  end
endmodule

// File: rtl/fpstk_tags.sv
// Valid tag per physical entry.
module fpstk_tags #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [PW-1:0]    set_addr,
  input  logic             clr_en,
  input  logic [PW-1:0]    clr_addr,
  input  logic             clr_all,
  output logic [DEPTH-1:0] tags_q
);
  logic [DEPTH-1:0] tags_nxt;
  logic             tags_en;

  always_comb begin
    tags_en  = set_en || clr_en || clr_all;
    tags_nxt = tags_q;
    if (clr_all) begin
      tags_nxt = '0;
    end else begin
      if (set_en) tags_nxt[set_addr] = 1'b1;
      if (clr_en) tags_nxt[clr_addr] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tags_q <= '0;
    else if (tags_en) tags_q <= tags_nxt;
  end
endmodule

// File: rtl/fpstk_regs.sv
// Data entries: two write ports, two combinational read ports.
module fpstk_regs #(
  parameter int DEPTH = 8,
  parameter int W     = 80,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wa_en,
  input  logic [PW-1:0] wa_addr,
  input  logic [W-1:0]  wa_data,
  input  logic          wb_en,
  input  logic [PW-1:0] wb_addr,
  input  logic [W-1:0]  wb_data,
  input  logic [PW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [PW-1:0] rb_addr,
  output logic [W-1:0]  rb_data
);
  logic [DEPTH-1:0][W-1:0] mem_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic         hit_a, hit_b, ent_en;
    logic [W-1:0] ent_nxt;
    always_comb begin
      hit_a   = wa_en && (wa_addr == PW'(g));
      hit_b   = wb_en && (wb_addr == PW'(g));
      ent_en  = hit_a || hit_b;
      ent_nxt = hit_a ? wa_data : wb_data;
    end
    always_ff @(posedge clk) begin
      if (ent_en) mem_q[g] <= ent_nxt;
    end
  end

  always_comb begin
    ra_data = mem_q[ra_addr];
    rb_data = mem_q[rb_addr];
  end
endmodule

// File: rtl/fpstk_file.sv
module fpstk_file #(
  parameter int DEPTH = 8,
  parameter int W     = 80,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [PW-1:0]    cmd_idx,
  input  logic             cmd_pop,
  input  logic [W-1:0]     wr_data,
  output logic [W-1:0]     rd_data,
  output logic             rd_valid,
  output logic [PW-1:0]    top_o,
  output logic [DEPTH-1:0] tags_o,
  output logic             stk_fault,
  output logic             inv_op,
  output logic             c1_dir
);
  // reset synchroniser: assert asynchronously, release on clock
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  logic [PW-1:0]    top_q, top_nxt, addr_dec, addr_rel;
  logic [DEPTH-1:0] tags_q;
  logic             ovf, unf, do_push, do_read, do_xchg, do_pop, do_init;
  logic [W-1:0]     st0_data, sti_data;

  fpstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx), .cmd_pop(cmd_pop),
    .top_q(top_q), .tags_q(tags_q), .top_nxt(top_nxt), .addr_dec(addr_dec),
    .addr_rel(addr_rel), .ovf(ovf), .unf(unf), .do_push(do_push),
    .do_read(do_read), .do_xchg(do_xchg), .do_pop(do_pop), .do_init(do_init)
  );

  fpstk_tags #(.DEPTH(DEPTH)) u_tags (
    .clk(clk), .rst_n(rst_q),
    .set_en(do_push), .set_addr(addr_dec),
    .clr_en(do_pop), .clr_addr(top_q),
    .clr_all(do_init), .tags_q(tags_q)
  );

  logic          wa_en;
  logic [PW-1:0] wa_addr;
  logic [W-1:0]  wa_data;
  always_comb begin
    wa_en   = do_push || do_xchg;
    wa_addr = do_push ? addr_dec : top_q;
    wa_data = do_push ? wr_data  : sti_data;
  end

  fpstk_regs #(.DEPTH(DEPTH), .W(W)) u_regs (
    .clk(clk),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .wb_en(do_xchg), .wb_addr(addr_rel), .wb_data(st0_data),
    .ra_addr(top_q), .ra_data(st0_data),
    .rb_addr(addr_rel), .rb_data(sti_data)
  );

  // pointer
  logic top_en;
  always_comb top_en = (top_nxt != top_q) || do_init;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      top_q <= '0;
    else if (top_en) top_q <= top_nxt;
  end

  // result and fault outputs
  logic          flt_nxt, c1_nxt;
  logic [W-1:0]  rd_q;
  logic          rdv_q, flt_q, c1_q;
  always_comb begin
    flt_nxt = ovf || unf;
    c1_nxt  = ovf;
  end
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rdv_q <= 1'b0;
      flt_q <= 1'b0;
      c1_q  <= 1'b0;
    end else begin
      rdv_q <= do_read;
      flt_q <= flt_nxt;
      c1_q  <= c1_nxt;
    end
  end
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)       rd_q <= '0;
    else if (do_read) rd_q <= sti_data;
  end

  always_comb begin
    rd_data   = rd_q;
    rd_valid  = rdv_q;
    top_o     = top_q;
    tags_o    = tags_q;
    stk_fault = flt_q;
    inv_op    = flt_q;
    c1_dir    = c1_q;
  end
endmodule

// File: rtl/fpstk_chk.sv
module fpstk_chk #(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_op,
  input logic [PW-1:0]    cmd_idx,
  input logic             cmd_pop,
  input logic [PW-1:0]    top_o,
  input logic [DEPTH-1:0] tags_o,
  input logic             stk_fault,
  input logic             inv_op,
  input logic             c1_dir,
  input logic             rd_valid
);
  logic [PW-1:0] below, rel, above;
  always_comb begin
    below = top_o - PW'(1);
    above = top_o + PW'(1);
    rel   = top_o + cmd_idx;
  end

  p_init_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd6) |=> (top_o == '0 && tags_o == '0));

  p_push_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1 && !tags_o[below]) |=>
      (top_o == $past(below) && tags_o[top_o] && !stk_fault));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd1 && tags_o[below]) |=>
      (stk_fault && inv_op && c1_dir && $stable(top_o) && $stable(tags_o)));

  p_read_unf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd2 && !tags_o[rel]) |=>
      (stk_fault && inv_op && !c1_dir && !rd_valid && $stable(top_o)));

  p_nonpop_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3) && !cmd_pop) |=> $stable(top_o));

  p_incp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd4) |=> (top_o == $past(above) && $stable(tags_o)));

  p_decp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5) |=> (top_o == $past(below) && $stable(tags_o)));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !stk_fault |-> !c1_dir);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(top_o) && $stable(tags_o) && !stk_fault && !rd_valid));
endmodule

bind fpstk_file fpstk_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_q), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_idx(cmd_idx), .cmd_pop(cmd_pop), .top_o(top_o), .tags_o(tags_o),
  .stk_fault(stk_fault), .inv_op(inv_op), .c1_dir(c1_dir), .rd_valid(rd_valid)
);

// File: tb/fpstk_file_tb.sv
module fpstk_file_tb;
  localparam int W = 16;

  logic         clk, rst_n, cmd_valid, cmd_pop;
  logic [2:0]   cmd_op, cmd_idx;
  logic [W-1:0] wr_data, rd_data;
  logic         rd_valid, stk_fault, inv_op, c1_dir;
  logic [2:0]   top_o;
  logic [7:0]   tags_o;

  fpstk_file #(.DEPTH(8), .W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_pop(cmd_pop), .wr_data(wr_data), .rd_data(rd_data),
    .rd_valid(rd_valid), .top_o(top_o), .tags_o(tags_o), .stk_fault(stk_fault),
    .inv_op(inv_op), .c1_dir(c1_dir)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  logic [W-1:0] m_data [8];
  logic [7:0]   m_tag;
  logic [2:0]   m_top;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit model_unf(input logic [2:0] op, input logic [2:0] idx, input bit pop);
    logic [2:0] a;
    a = m_top + idx;
    return ((op == 3'd2) || (op == 3'd3)) && (!m_tag[a] || (((op == 3'd3) || pop) && !m_tag[m_top]));
  endfunction

  // drive at negedge, check at following negedge
  task automatic do_cmd(input bit v, input logic [2:0] op, input logic [2:0] idx,
                        input bit pop, input logic [W-1:0] d, input string req);
    bit e_ovf, e_unf, e_rdv;
    logic [W-1:0] e_rd, tmp;
    logic [2:0] a, p;
    cmd_valid = v; cmd_op = op; cmd_idx = idx; cmd_pop = pop; wr_data = d;
    a = m_top + idx; p = m_top - 3'd1;
    e_ovf = v && (op == 3'd1) && m_tag[p];
    e_unf = v && model_unf(op, idx, pop);
    e_rdv = v && (op == 3'd2) && !e_unf;
    e_rd  = m_data[a];
    if (v && !e_ovf && !e_unf) begin
      case (op)
        3'd1: begin m_top = p; m_data[p] = d; m_tag[p] = 1'b1; end
        3'd2: if (pop) begin m_tag[m_top] = 1'b0; m_top = m_top + 3'd1; end
        3'd3: begin
          tmp = m_data[m_top]; m_data[m_top] = m_data[a]; m_data[a] = tmp;
          if (pop) begin m_tag[m_top] = 1'b0; m_top = m_top + 3'd1; end
        end
        3'd4: m_top = m_top + 3'd1;
        3'd5: m_top = m_top - 3'd1;
        3'd6: begin m_top = 3'd0; m_tag = 8'h00; end
        default: ;
      endcase
    end
    @(negedge clk);
    chk(top_o == m_top, req, "top", top_o, m_top);
    chk(tags_o == m_tag, req, "tags", tags_o, m_tag);
    chk(stk_fault == (e_ovf || e_unf), req, "stk_fault", stk_fault, e_ovf || e_unf);
    chk(inv_op == (e_ovf || e_unf), req, "inv_op", inv_op, e_ovf || e_unf);
    chk(c1_dir == e_ovf, req, "c1_dir", c1_dir, e_ovf);
    chk(rd_valid == e_rdv, req, "rd_valid", rd_valid, e_rdv);
    if (e_rdv) chk(rd_data == e_rd, req, "rd_data", rd_data, e_rd);
    cmd_valid = 1'b0;
  endtask

  // scan every slot by non-pop reads (checks stored data, R2/R6/R7)
  task automatic scan(input string req);
    for (int i = 0; i < 8; i++)
      if (m_tag[3'(m_top + 3'(i))]) do_cmd(1, 3'd2, 3'(i), 0, '0, req);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++; checks++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    cmd_valid = 0; cmd_op = 0; cmd_idx = 0; cmd_pop = 0; wr_data = '0;
    m_top = 0; m_tag = 0;
    for (int i = 0; i < 8; i++) m_data[i] = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(top_o == 3'd0, "R1", "reset top", top_o, 0);
    chk(tags_o == 8'h00, "R1", "reset tags", tags_o, 0);
    chk(!stk_fault && !rd_valid, "R1", "reset flags", stk_fault, 0);

    // R4 underflow on empty stack, then R8 pulse drops
    do_cmd(1, 3'd2, 3'd0, 0, '0, "R4");
    do_cmd(1, 3'd3, 3'd1, 0, '0, "R4");
    do_cmd(1, 3'd0, 3'd0, 0, '0, "R8");
    // R2 fill all eight
    for (int i = 0; i < 8; i++) do_cmd(1, 3'd1, 3'd0, 0, W'(16'h1000 + i), "R2");
    scan("R2");
    // R3 overflow on full stack, data intact
    do_cmd(1, 3'd1, 3'd0, 0, 16'hDEAD, "R3");
    do_cmd(1, 3'd0, 3'd0, 0, '0, "R8");
    scan("R3");
    // R9 idle and reserved ops have no effect
    do_cmd(0, 3'd1, 3'd0, 0, 16'hBEEF, "R9");
    do_cmd(1, 3'd7, 3'd2, 1, 16'hBEEF, "R9");
    // R7 exchange
    do_cmd(1, 3'd3, 3'd5, 0, '0, "R7");
    scan("R7");
    // R5 pops
    do_cmd(1, 3'd2, 3'd0, 1, '0, "R5");
    do_cmd(1, 3'd2, 3'd3, 1, '0, "R5");
    do_cmd(1, 3'd3, 3'd2, 1, '0, "R5");
    // R4 underflow: ST(7) now empty; pop needs ST(0)
    do_cmd(1, 3'd2, 3'd7, 0, '0, "R4");
    // R6 rotate through both wraps
    for (int i = 0; i < 10; i++) do_cmd(1, 3'd4, 3'd0, 0, '0, "R6");
    for (int i = 0; i < 12; i++) do_cmd(1, 3'd5, 3'd0, 0, '0, "R6");
    scan("R6");
    // R4 read of empty with pop at rotated pointer
    do_cmd(1, 3'd2, 3'd0, 1, '0, "R4");
    // R1 init
    do_cmd(1, 3'd6, 3'd0, 0, '0, "R1");
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [2:0] op;
      r = int'($urandom_range(0, 99));
      if (r < 30)      op = 3'd1;
      else if (r < 50) op = 3'd2;
      else if (r < 65) op = 3'd3;
      else if (r < 77) op = 3'd4;
      else if (r < 89) op = 3'd5;
      else if (r < 91) op = 3'd6;
      else             op = 3'(r % 8);
      do_cmd(($urandom_range(0, 9) != 0), op, 3'($urandom_range(0, 7)),
             bit'($urandom_range(0, 1)), W'($urandom), "R9");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule